// File: doc/BRIEF.md
# Low-Rate Edge Noise Window Filter

This block screens the rising edges of a slow reference clock (nominally 2 kHz, 4 kHz or 8 kHz) before they reach a DPLL phase detector. It keeps a tick counter that starts at the last accepted edge. A programmed nominal period, counted in system-clock ticks, tells it where the next edge should land. While windowing is active, only an edge that falls inside a narrow tolerance band around that predicted point produces a qualified-edge pulse. Any other edge is treated as noise and dropped.

Windowing is active only when three conditions hold together: the enable is set, the loop reports lock, and the rate selection names a supported low rate. When any of them is missing, every edge is forwarded, so the loop can acquire. If the band closes with no edge inside it, the reference point moves forward by one nominal period and tracking goes on.

A three-state machine drives the block. SEEK holds no reference. EARLY is the span between a reference point and the opening of the band. INWIN is the band itself. The transitions are:

- lock-on: SEEK to EARLY, on the first edge after reset.
- restart: EARLY to EARLY, on an edge forwarded while windowing is inactive.
- open: EARLY to INWIN, when the counter reaches the band start.
- accept: INWIN to EARLY, on any edge inside the band.
- slip: INWIN to EARLY, when the band end passes with no edge.

Top module: `enf_noise_window`

## Requirements
- R1: After reset, edge_ok is 0 and no reference point is held (state SEEK).
- R2: ref_in passes through a two-flop synchroniser and a previous-sample compare. Each low-to-high transition gives exactly one single-cycle edge_ok pulse when accepted. The pulse is high after the clock edge two cycles after the first edge that samples ref_in high.
- R3: The first rising edge after reset is always accepted, and it sets the reference point.
- R4: With win_en = 0, every rising edge is accepted and restarts the reference point.
- R5: With locked = 0, every rising edge is accepted and restarts the reference point.
- R6: rate_sel codes 0, 1 and 2 (2, 4 and 8 kHz) allow windowing. Code 3 is unsupported, and with it every edge is accepted.
- R7: The tolerance is T = (P>>6)+(P>>7)+(P>>10)+(P>>11), about P/40, where P is nom_period. The band spans P−T to P+T ticks after the reference point, with both ends included. Ticks are counted between the sample edges at which ref_in is first seen high.
- R8: While windowing is active, an edge fewer than P−T ticks after the reference point produces no pulse and does not move the reference point.
- R9: While windowing is active, an edge later than P+T ticks after the reference point produces no pulse.
- R10: If no edge is accepted by P+T ticks, the reference point advances by exactly P ticks (slip). The next band is then measured from the advanced point.
- R11: Edges exactly P−T and exactly P+T ticks after the reference point are accepted.
- R12: While a reference is held, the tick counter never exceeds P+T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Low-rate reference clock |
| nom_period | input | PW | Nominal reference period in clock ticks |
| win_en | input | 1 | Noise window enable |
| locked | input | 1 | Loop lock indication |
| rate_sel | input | 2 | Reference rate code: 0 = 2 kHz, 1 = 4 kHz, 2 = 8 kHz, 3 = unsupported |
| edge_ok | output | 1 | Single-cycle qualified-edge pulse |

## Verification
The hardest situation to reach is a slip followed by judgement against the advanced reference point. To get there, the stimulus first places an edge just past the band end, so the slip fires with no edge accepted. It then places later edges at offsets that are only acceptable when measured from the moved point, not from the original one. A second hard case is an edge on the exact first or last tick of the band. The bench drives edge spacings in whole cycles to hit those ticks precisely, and it repeats them after an early edge has been rejected, to show the reference point stayed put.

// File: rtl/enf_pkg.sv
package enf_pkg;

    typedef enum logic [1:0] {
        S_SEEK  = 2'd0,
        S_EARLY = 2'd1,
        S_INWIN = 2'd2
    } trk_state_t;

    localparam logic [1:0] RATE_2K   = 2'd0;
    localparam logic [1:0] RATE_4K   = 2'd1;
    localparam logic [1:0] RATE_8K   = 2'd2;

    // about one fortieth of the period, shift-and-add only
    function automatic int unsigned frac40(input int unsigned p);
        return (p >> 6) + (p >> 7) + (p >> 10) + (p >> 11);
    endfunction

endpackage

// File: rtl/enf_edge_det.sv
module enf_edge_det #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [SYNC-1:0] sy;
    logic            prev;

    generate
        if (SYNC == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sy <= '0;
                else        sy <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sy <= '0;
                else        sy <= {sy[SYNC-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= sy[SYNC-1];
    end

    assign rise = sy[SYNC-1] & ~prev;
endmodule

// File: rtl/enf_window.sv
module enf_window #(
    parameter int PW = 17,
    localparam int CW = PW + 1
) (
    input  logic [PW-1:0] period,
    output logic [PW-1:0] tol,
    output logic [CW-1:0] lo,
    output logic [CW-1:0] hi
);
    always_comb begin
        tol = PW'(enf_pkg::frac40(32'(period)));
        lo  = CW'(period) - CW'(tol);
        hi  = CW'(period) + CW'(tol);
    end
endmodule

// File: rtl/enf_mode_gate.sv
module enf_mode_gate (
    input  logic       win_en,
    input  logic       locked,
    input  logic [1:0] rate_sel,
    output logic       filt_on
);
    logic rate_ok;

    always_comb begin
        unique case (rate_sel)
            enf_pkg::RATE_2K,
            enf_pkg::RATE_4K,
            enf_pkg::RATE_8K: rate_ok = 1'b1;
            default:          rate_ok = 1'b0;
        endcase
        filt_on = win_en & locked & rate_ok;
    end
endmodule

// File: rtl/enf_noise_window.sv
module enf_noise_window #(
    parameter int PW   = 17,
    parameter int SYNC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_in,
    input  logic [PW-1:0] nom_period,
    input  logic          win_en,
    input  logic          locked,
    input  logic [1:0]    rate_sel,
    output logic          edge_ok
);
    import enf_pkg::*;

    localparam int CW = PW + 1;

    logic          rise;
    logic          filt_on;
    logic [PW-1:0] tol;
    logic [CW-1:0] win_lo;
    logic [CW-1:0] win_hi;

    trk_state_t    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt, cnt_inc;
    logic          acc;

    enf_edge_det #(.SYNC(SYNC)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ref_in),
        .rise (rise)
    );

    enf_window #(.PW(PW)) u_win (
        .period(nom_period),
        .tol   (tol),
        .lo    (win_lo),
        .hi    (win_hi)
    );

    enf_mode_gate u_gate (
        .win_en  (win_en),
        .locked  (locked),
        .rate_sel(rate_sel),
        .filt_on (filt_on)
    );

    assign cnt_inc = cnt + CW'(1);

    // next state, counter and accept decision
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        acc     = 1'b0;
        unique case (state)
            S_SEEK: begin
                if (rise) begin                 // lock-on
                    acc     = 1'b1;
                    cnt_nxt = CW'(1);
                    nxt     = S_EARLY;
                end
            end
            S_EARLY: begin
                if (rise && !filt_on) begin     // restart
                    acc     = 1'b1;
                    cnt_nxt = CW'(1);
                    nxt     = S_EARLY;
                end else begin
                    cnt_nxt = cnt_inc;
                    if (cnt_inc >= win_lo)      // open
                        nxt = S_INWIN;
                end
            end
            S_INWIN: begin
                if (rise) begin                 // accept
                    acc     = 1'b1;
                    cnt_nxt = CW'(1);
                    nxt     = S_EARLY;
                end else if (cnt >= win_hi) begin  // slip by one period
                    cnt_nxt = CW'(tol) + CW'(1);
                    nxt     = S_EARLY;
                end else begin
                    cnt_nxt = cnt_inc;
                end
            end
            default: begin
                nxt     = S_SEEK;
                cnt_nxt = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_SEEK;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edge_ok <= 1'b0;
        else        edge_ok <= acc;
    end
endmodule

// File: rtl/enf_noise_window_chk.sv
module enf_noise_window_chk #(
    parameter int PW = 17,
    localparam int CW = PW + 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                rise,
    input logic                filt_on,
    input logic                edge_ok,
    input enf_pkg::trk_state_t st,
    input logic [CW-1:0]       cnt,
    input logic [CW-1:0]       lo,
    input logic [CW-1:0]       hi
);
    import enf_pkg::*;

    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ok |=> !edge_ok);

    a_r2_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        edge_ok |-> $past(rise));

    a_r3_first_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_SEEK && rise) |=> edge_ok);

    a_r4_bypass_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && !filt_on) |=> edge_ok);

    a_r8_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (rise && filt_on && st == S_EARLY) |=> !edge_ok);

    a_r10_slip: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_INWIN && !rise && cnt == hi) |=>
        (st == S_EARLY && cnt == ((hi - lo) >> 1) + CW'(1)));

    a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_SEEK) |-> (cnt <= hi));
endmodule

bind enf_noise_window enf_noise_window_chk #(.PW(PW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise),
    .filt_on(filt_on),
    .edge_ok(edge_ok),
    .st     (state),
    .cnt    (cnt),
    .lo     (win_lo),
    .hi     (win_hi)
);

// File: tb/tb_enf_noise_window.sv
module tb_enf_noise_window;
    localparam int PW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ref_in = 1'b0;
    logic [PW-1:0] nom_period = PW'(200);
    logic          win_en = 1'b0;
    logic          locked = 1'b0;
    logic [1:0]    rate_sel = 2'd0;
    logic          edge_ok;

    always #4 clk = ~clk;   // 125 MHz

    enf_noise_window #(.PW(PW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .nom_period(nom_period),
        .win_en    (win_en),
        .locked    (locked),
        .rate_sel  (rate_sel),
        .edge_ok   (edge_ok)
    );

    int    compared = 0;
    int    mismatched = 0;
    int    pulses = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference model: edge times and reference point in cycles
    int cyc, ref_time;
    bit have_ref, r1, r2, r3, exp_out;

    always @(posedge clk or negedge rst_n) begin : model
        int t, lo, hi, d, p;
        bit rise, active, acc;
        if (!rst_n) begin
            cyc = 0; ref_time = 0; have_ref = 0;
            r1 = 0; r2 = 0; r3 = 0; exp_out = 0;
        end else begin
            cyc++;
            p      = int'(nom_period);
            t      = (p >> 6) + (p >> 7) + (p >> 10) + (p >> 11);
            lo     = p - t;
            hi     = p + t;
            rise   = r2 && !r3;
            active = win_en && locked && (rate_sel != 2'd3);
            d      = cyc - ref_time;
            acc    = rise && (!have_ref || !active || (d >= lo && d <= hi));
            if (acc) begin
                have_ref = 1;
                ref_time = cyc;
            end else if (have_ref && d == hi) begin
                ref_time = ref_time + p;
            end
            exp_out = acc;
            r3 = r2; r2 = r1; r1 = ref_in;
        end
    end

    // compared on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            compared++;
            if (edge_ok !== exp_out) begin
                mismatched++;
                $display("FAIL %s cycle %0d edge_ok actual %b expected %b",
                         cur_req, cyc, edge_ok, exp_out);
            end
            if (edge_ok === 1'b1) pulses++;
        end
    end

    task automatic check_count(input string req, input int exp_n);
        compared++;
        if (pulses != exp_n) begin
            mismatched++;
            $display("FAIL %s pulse count actual %0d expected %0d", req, pulses, exp_n);
        end
    endtask

    task automatic start(input int p, input bit en, input bit lk, input logic [1:0] rs,
                         input string req);
        @(negedge clk);
        rst_n      = 1'b0;
        ref_in     = 1'b0;
        nom_period = PW'(p);
        win_en     = en;
        locked     = lk;
        rate_sel   = rs;
        cur_req    = req;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        pulses = 0;
    endtask

    // raise ref_in now; next call raises exactly d cycles later
    task automatic send(input int d);
        ref_in = 1'b1;
        repeat (4) @(negedge clk);
        ref_in = 1'b0;
        repeat (d - 4) @(negedge clk);
    endtask

    task automatic finish_run();
        repeat (6) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : stim
        // R1: reset state, no stimulus
        start(200, 1'b1, 1'b1, 2'd0, "R1");
        repeat (5) @(negedge clk);
        compared++;
        if (edge_ok !== 1'b0) begin
            mismatched++;
            $display("FAIL R1 edge_ok after reset actual %b expected 0", edge_ok);
        end
        check_count("R1", 0);

        // R4 bypass by enable, R3 first edge, R2 single pulse per edge
        start(200, 1'b0, 1'b1, 2'd0, "R4/R3/R2");
        send(200); send(37); send(90); send(200); send(20);
        finish_run();
        check_count("R4", 5);

        // R5 bypass while unlocked
        start(200, 1'b1, 1'b0, 2'd1, "R5");
        send(200); send(37); send(90); send(200); send(20);
        finish_run();
        check_count("R5", 5);

        // R6 unsupported rate code 3 passes all
        start(200, 1'b1, 1'b1, 2'd3, "R6");
        send(200); send(37); send(90); send(200); send(20);
        finish_run();
        check_count("R6", 5);

        // R7 R11 R8: P=200, T=4, band 196..204
        start(200, 1'b1, 1'b1, 2'd0, "R7/R8/R11");
        send(196);   // first edge accepted
        send(204);   // at 196: accepted (low boundary)
        send(195);   // at 204: accepted (high boundary)
        send(9);     // at 195: rejected early
        send(100);   // at 204 from reference: accepted
        send(100);   // at 100: rejected
        send(50);    // at 200: accepted
        send(20);    // at 50: rejected
        finish_run();
        check_count("R8", 5);

        // R9 R10: late edge rejected, reference slips by P
        start(200, 1'b1, 1'b1, 2'd1, "R9/R10");
        send(205);   // first edge accepted at t0
        send(195);   // t0+205: late, slip to t0+200 -> distance 5, rejected
        send(300);   // t0+400: accepted
        send(110);   // t0+700: after slip to t0+600, rejected
        send(190);   // t0+810: after slip to t0+800, rejected
        send(20);    // t0+1000: accepted
        finish_run();
        check_count("R10", 3);

        // R7 R11 at P=1000, T=22, band 978..1022, rate code 2
        start(1000, 1'b1, 1'b1, 2'd2, "R7/R9/R10/R11");
        send(978);   // first edge
        send(1023);  // at 978: accepted
        send(977);   // at 1023: rejected, slip leaves distance 23
        send(1022);  // at 1000 from slipped point: accepted
        send(20);    // at 1022: accepted
        finish_run();
        check_count("R11", 4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule